// File: doc/BRIEF.md
# Power-Good Strap Latch and PLL Mode Selector

This block sequences a clock buffer's start-up and low-power entry from one combined power-good / power-down pin. The first time the pin reads high after reset, the block captures the configuration straps: a three-level PLL mode strap, seen as two comparator outputs, and a frequency-select strap. It then brings the outputs up. From then on, a low level on the same pin puts the device into power-down and a high level brings it back. The straps are not sampled again until the next reset.

The active PLL mode is either the latched strap mode or, when the software-control bit is set, a mode code supplied from the control register. Whichever source is active, the register's readback field keeps showing the strap value. The block also drives a PLL-off flag, a flag that shows the outputs are driving after a fixed wake delay, and the assembled read-only view of the mode/frequency control byte.

Top module: `pwrgd_mode_ctl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pwr_down`=1, `clk_run`=0, `cfg_latched`=0, `pll_off`=1, `fsel`=1, and the strap readback `status_byte[7:6]`=01 (bypass).
- R2: `pg_pd_n` passes through SYNC_STAGES flops. The first high level after reset sets `cfg_latched` and clears `pwr_down` at the SYNC_STAGES+1-th rising edge after the change, and captures the straps on that edge. A low level before that changes nothing.
- R3: The strap pair {`strap_hi`,`strap_lo`} decodes as 00 to low bandwidth (code 00), 01 to bypass (code 01), 11 to high bandwidth (code 11), and the invalid 10 to bypass. With software control off, `mode_code` shows the latched strap mode.
- R4: After the first capture, later changes of the strap inputs and later power-down cycles leave `status_byte[7:6]` and `fsel` unchanged.
- R5: Once started, a low level on `pg_pd_n` sets `pwr_down` and clears `clk_run` SYNC_STAGES+1 edges later. A later high level clears `pwr_down` with the same latency.
- R6: On each exit from power-down, including the first start, `clk_run` rises exactly WAKE_CYCLES rising edges after `pwr_down` falls. It never stays low longer than that while `pwr_down` is 0.
- R7: With `sw_mode_en`=1, `mode_code` follows `sw_mode_code` in the same cycle (00 low, 01 bypass, 11 high, 10 treated as bypass), and `status_byte[7:6]` still shows the strap mode. `mode_code` never takes the value 10.
- R8: `pll_off` is 1 exactly when the active mode is bypass or `pwr_down` is 1.
- R9: `status_byte` is laid out as [7:6] latched strap mode, [5:4] zero, [3] `sw_mode_en`, [2:1] `sw_mode_code`, [0] latched frequency strap (1 means 100 MHz, 0 means 133.33 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_n | input | 1 | Combined power-good (first high) / power-down (low) pin |
| strap_hi | input | 1 | Mode strap comparator: level above the upper threshold |
| strap_lo | input | 1 | Mode strap comparator: level above the lower threshold |
| strap_fsel | input | 1 | Frequency strap, 1 = 100 MHz, 0 = 133.33 MHz |
| sw_mode_en | input | 1 | Register bit: software mode control enable |
| sw_mode_code | input | 2 | Register bits: software mode code |
| mode_code | output | 2 | Active PLL mode code |
| pll_off | output | 1 | PLL disabled |
| fsel | output | 1 | Latched frequency select |
| pwr_down | output | 1 | Device held in power-down (or not yet started) |
| clk_run | output | 1 | Outputs are driving |
| cfg_latched | output | 1 | Straps have been captured since reset |
| status_byte | output | 8 | Read-only view of the mode/frequency control byte |

## Verification
The assertions check on every cycle that the PLL-off flag agrees with the mode and the power-down state, that the reserved readback bits stay zero, that the invalid mode code never appears, that the capture flag never drops, that the readback and frequency stay frozen once captured, and that no wake window runs past WAKE_CYCLES. Only the bench's scenarios can show the strap decode for each comparator pair and frequency value, the exact synchronizer and wake latencies, and that straps changed after the first start are ignored across a power-down cycle. The same goes for the software override of every code while the readback still holds the strap value.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [1:0] {
        MODE_LOBW = 2'b00,
        MODE_BYP  = 2'b01,
        MODE_HIBW = 2'b11
    } pll_mode_e;

    typedef enum logic [1:0] {
        SEQ_INIT,
        SEQ_WAKE,
        SEQ_RUN,
        SEQ_PDN
    } seq_state_e;

    typedef struct packed {
        pll_mode_e mode;
        logic      fsel;
    } strap_cfg_t;

    localparam strap_cfg_t CFG_RESET = '{mode: MODE_BYP, fsel: 1'b1};

    // Comparator pair to mode; the inconsistent pair falls back to the mid level.
    function automatic pll_mode_e decode_tri(logic above_hi, logic above_lo);
        pll_mode_e m;
        case ({above_hi, above_lo})
            2'b00:   m = MODE_LOBW;
            2'b11:   m = MODE_HIBW;
            default: m = MODE_BYP;
        endcase
        return m;
    endfunction

    // Register code to mode; the undefined code selects bypass.
    function automatic pll_mode_e decode_code(logic [1:0] code);
        pll_mode_e m;
        case (code)
            2'b00:   m = MODE_LOBW;
            2'b11:   m = MODE_HIBW;
            default: m = MODE_BYP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pg_seq.sv
module pg_seq
    import pgm_pkg::*;
#(
    parameter int WAKE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_s,
    output seq_state_e state,
    output logic       capture
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

    seq_state_e     state_n;
    logic [CW-1:0]  wake_cnt;
    logic [CW-1:0]  wake_cnt_n;

    assign capture = (state == SEQ_INIT) && pg_s;

    always_comb begin
        state_n    = state;
        wake_cnt_n = wake_cnt;
        case (state)
            SEQ_INIT: begin
                if (pg_s) begin
                    state_n    = SEQ_WAKE;
                    wake_cnt_n = '0;
                end
            end
            SEQ_WAKE: begin
                if (!pg_s) begin
                    state_n = SEQ_PDN;
                end else if (wake_cnt == WAKE_LAST) begin
                    state_n = SEQ_RUN;
                end else begin
                    wake_cnt_n = wake_cnt + 1'b1;
                end
            end
            SEQ_RUN: begin
                if (!pg_s) state_n = SEQ_PDN;
            end
            SEQ_PDN: begin
                if (pg_s) begin
                    state_n    = SEQ_WAKE;
                    wake_cnt_n = '0;
                end
            end
            default: state_n = SEQ_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_INIT;
            wake_cnt <= '0;
        end else begin
            state    <= state_n;
            wake_cnt <= wake_cnt_n;
        end
    end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import pgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic       above_hi,
    input  logic       above_lo,
    input  logic       fsel_in,
    output strap_cfg_t cfg,
    output logic       valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            valid <= 1'b0;
        end else if (capture && !valid) begin
            cfg.mode <= decode_tri(above_hi, above_lo);
            cfg.fsel <= fsel_in;
            valid    <= 1'b1;
        end
    end
endmodule

// File: rtl/mode_resolve.sv
module mode_resolve
    import pgm_pkg::*;
(
    input  strap_cfg_t cfg,
    input  logic       sw_en,
    input  logic [1:0] sw_code,
    input  logic       pdn,
    output pll_mode_e  mode,
    output logic       pll_off,
    output logic [7:0] status
);
    always_comb begin
        mode    = sw_en ? decode_code(sw_code) : cfg.mode;
        pll_off = (mode == MODE_BYP) || pdn;
        status  = {cfg.mode, 2'b00, sw_en, sw_code, cfg.fsel};
    end
endmodule

// File: rtl/pwrgd_mode_ctl.sv
module pwrgd_mode_ctl
    import pgm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_pd_n,
    input  logic       strap_hi,
    input  logic       strap_lo,
    input  logic       strap_fsel,
    input  logic       sw_mode_en,
    input  logic [1:0] sw_mode_code,
    output logic [1:0] mode_code,
    output logic       pll_off,
    output logic       fsel,
    output logic       pwr_down,
    output logic       clk_run,
    output logic       cfg_latched,
    output logic [7:0] status_byte
);
    logic       pg_s;
    logic       capture;
    seq_state_e state;
    strap_cfg_t cfg;
    pll_mode_e  mode;

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pg_pd_n),
        .q   (pg_s)
    );

    pg_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pg_s    (pg_s),
        .state   (state),
        .capture (capture)
    );

    strap_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .above_hi (strap_hi),
        .above_lo (strap_lo),
        .fsel_in  (strap_fsel),
        .cfg      (cfg),
        .valid    (cfg_latched)
    );

    assign pwr_down = (state == SEQ_INIT) || (state == SEQ_PDN);
    assign clk_run  = (state == SEQ_RUN);
    assign fsel     = cfg.fsel;

    mode_resolve u_mode (
        .cfg     (cfg),
        .sw_en   (sw_mode_en),
        .sw_code (sw_mode_code),
        .pdn     (pwr_down),
        .mode    (mode),
        .pll_off (pll_off),
        .status  (status_byte)
    );

    assign mode_code = mode;
endmodule

// File: rtl/pwrgd_mode_ctl_chk.sv
module pwrgd_mode_ctl_chk #(
    parameter int WAKE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_code,
    input logic       pll_off,
    input logic       fsel,
    input logic       pwr_down,
    input logic       clk_run,
    input logic       cfg_latched,
    input logic [7:0] status_byte
);
    localparam int CW = $clog2(WAKE_CYCLES + 2);
    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || pwr_down || clk_run) wait_cnt <= '0;
        else                             wait_cnt <= wait_cnt + 1'b1;
    end

    assert_wake_window_R6: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CW'(WAKE_CYCLES));

    assert_run_not_down_R6: assert property (@(posedge clk) disable iff (rst)
        clk_run |-> !pwr_down);

    assert_latch_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_latched |=> cfg_latched);

    assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_latched && $past(cfg_latched)) |-> ($stable(status_byte[7:6]) && $stable(fsel)));

    assert_no_bad_code_R7: assert property (@(posedge clk) disable iff (rst)
        mode_code != 2'b10);

    assert_pll_off_R8: assert property (@(posedge clk) disable iff (rst)
        pll_off == ((mode_code == 2'b01) || pwr_down));

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        status_byte[5:4] == 2'b00);

    assert_unlatched_down_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_latched |-> pwr_down);
endmodule

bind pwrgd_mode_ctl pwrgd_mode_ctl_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_code   (mode_code),
    .pll_off     (pll_off),
    .fsel        (fsel),
    .pwr_down    (pwr_down),
    .clk_run     (clk_run),
    .cfg_latched (cfg_latched),
    .status_byte (status_byte)
);

// File: tb/pwrgd_mode_ctl_test.sv
module pwrgd_mode_ctl_test;
    localparam int SYNC = 2;
    localparam int W    = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pg_pd_n = 1'b0;
    logic       strap_hi = 1'b0;
    logic       strap_lo = 1'b0;
    logic       strap_fsel = 1'b1;
    logic       sw_mode_en = 1'b0;
    logic [1:0] sw_mode_code = 2'b00;
    logic [1:0] mode_code;
    logic       pll_off, fsel, pwr_down, clk_run, cfg_latched;
    logic [7:0] status_byte;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwrgd_mode_ctl #(.SYNC_STAGES(SYNC), .WAKE_CYCLES(W)) uut (
        .clk(clk), .rst(rst), .pg_pd_n(pg_pd_n), .strap_hi(strap_hi),
        .strap_lo(strap_lo), .strap_fsel(strap_fsel), .sw_mode_en(sw_mode_en),
        .sw_mode_code(sw_mode_code), .mode_code(mode_code), .pll_off(pll_off),
        .fsel(fsel), .pwr_down(pwr_down), .clk_run(clk_run),
        .cfg_latched(cfg_latched), .status_byte(status_byte)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [1:0] exp_mode(logic [1:0] c);
        return (c == 2'b10) ? 2'b01 : c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pg_pd_n = 1'b0; sw_mode_en = 1'b0; sw_mode_code = 2'b00;
        ticks(2);
        rst = 1'b0;
        ticks(1);
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        ticks(1);
        // R1 reset state
        check("R1 pwr_down", pwr_down, 1);
        check("R1 clk_run", clk_run, 0);
        check("R1 cfg_latched", cfg_latched, 0);
        check("R1 pll_off", pll_off, 1);
        check("R1 fsel", fsel, 1);
        check("R1 status", status_byte, 8'b0100_0001);
        // R2 low level before first start does nothing
        ticks(6);
        check("R2 no latch while low", cfg_latched, 0);
        check("R2 still down", pwr_down, 1);

        for (int t = 0; t < 4; t++) begin
            for (int f = 0; f < 2; f++) begin
                logic [1:0] em;
                em = exp_mode(t[1:0]);
                do_reset();
                strap_hi = t[1]; strap_lo = t[0]; strap_fsel = f[0];
                pg_pd_n = 1'b1;
                ticks(SYNC);
                check("R2 not yet latched", cfg_latched, 0);
                ticks(1);
                check("R2 latched", cfg_latched, 1);
                check("R2 pwr_down cleared", pwr_down, 0);
                check("R3 readback", status_byte[7:6], em);
                check("R3 mode_code", mode_code, em);
                check("R9 fsel bit", status_byte[0], f);
                check("R9 fsel", fsel, f);
                check("R8 pll_off strap", pll_off, (em == 2'b01));
                ticks(W - 1);
                check("R6 wake not done", clk_run, 0);
                ticks(1);
                check("R6 wake done", clk_run, 1);
                // change straps, then power-down cycle
                strap_hi = ~t[1]; strap_lo = ~t[0]; strap_fsel = ~f[0];
                ticks(2);
                check("R4 straps ignored", status_byte[7:6], em);
                pg_pd_n = 1'b0;
                ticks(SYNC);
                check("R5 pd latency", pwr_down, 0);
                ticks(1);
                check("R5 pd entered", pwr_down, 1);
                check("R5 clk stopped", clk_run, 0);
                check("R8 pll_off in pd", pll_off, 1);
                pg_pd_n = 1'b1;
                ticks(SYNC + 1);
                check("R5 pd exit", pwr_down, 0);
                check("R4 readback held", status_byte[7:6], em);
                check("R4 fsel held", fsel, f);
                check("R3 mode after pd", mode_code, em);
                ticks(W - 1);
                check("R6 rewake not done", clk_run, 0);
                ticks(1);
                check("R6 rewake done", clk_run, 1);
                // software override sweep
                for (int c = 0; c < 4; c++) begin
                    sw_mode_en = 1'b1; sw_mode_code = c[1:0];
                    ticks(1);
                    check("R7 override", mode_code, exp_mode(c[1:0]));
                    check("R7 readback strap", status_byte[7:6], em);
                    check("R8 pll_off sw", pll_off, (exp_mode(c[1:0]) == 2'b01));
                    check("R9 sw bits", status_byte[5:1], {2'b00, 1'b1, c[1:0]});
                end
                sw_mode_en = 1'b0;
                ticks(1);
                check("R7 back to strap", mode_code, em);
                check("R9 en bit clear", status_byte[3], 0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule